// File: doc/BRIEF.md
# PWM Duty Cycle Window Monitor

This block watches a single pulse-width-modulated input running at a fixed frequency and raises an alarm when a high pulse is too short or too long. It times each high pulse by counting ticks from a programmable divider of the system clock. It then compares that count with a low limit and a high limit. A long pulse is flagged while it is still high, as soon as its count passes the high limit. A short pulse is judged once, when the input falls.

The pulse input may be asynchronous to the system clock. It is retimed inside the block. The limit inputs are plain levels that may change at any time. The block copies them into working registers only at the start of each measured pulse, so a pulse is always judged against one consistent pair of limits. The alarms are sticky. A supervising controller clears them, together with the measurement state, by pulling the asynchronous clear low. The block has no streaming data path, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `pwm_duty_window_mon`

## Requirements
- R1: The input is retimed by two flops, and a rising edge is acted on at the third clock edge after the input rises. The width count then restarts from zero, and the tick divider restarts with it. A tick occurs every `prescale`+1 clock cycles. For a high time of H whole clock cycles the final count is floor((H-1)/(`prescale`+1)).
- R2: At the falling edge of a measured pulse, `alarm_lo` is set when the count is strictly less than the working low limit. A count equal to the low limit does not set it.
- R3: `alarm_hi` is set one cycle after the count first exceeds the working high limit, while the input is still high, and the count then stops. A count equal to the high limit does not set it.
- R4: `lim_lo` and `lim_hi` are copied into the working limits only at a rising edge. A change during a pulse has no effect on that pulse and applies from the next pulse on.
- R5: Once set, each alarm stays set through later in-range pulses until the clear is asserted.
- R6: The count saturates at its all-ones value and does not wrap. With both limits at all-ones, a very long pulse raises neither alarm.
- R7: `alarm_any` is high exactly when at least one of `alarm_lo` and `alarm_hi` is high.
- R8: Driving `clr_n` low clears both alarms and the measurement state at once, without waiting for a clock edge. Release is synchronized to the clock. A pulse that is already high when the clear is released is not measured, and its falling edge raises no alarm. The next rising edge starts a normal measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear from the supervisor. Asserted asynchronously, released synchronously |
| prescale | input | PRE_W | Tick period minus one, in clock cycles |
| pwm_in | input | 1 | Asynchronous pulse input |
| lim_lo | input | CNT_W | Low limit, in ticks |
| lim_hi | input | CNT_W | High limit, in ticks |
| alarm_lo | output | 1 | Sticky flag for a pulse that was too short |
| alarm_hi | output | 1 | Sticky flag for a pulse that was too long |
| alarm_any | output | 1 | OR of both alarms |

## Verification
The bench aims at the off-by-one limits: counts exactly equal to each limit, and counts one past them. A design that used the wrong comparison, or dropped the cycle lost to the rising-edge detection, would flag the equal cases or miss the one-past cases. The bench changes the limits in the middle of a pulse, which catches a design without the shadow copy: such a design would raise a high alarm on a pulse that was within its limits. A 5000-cycle pulse with all-ones limits exposes a wrapping counter, because the count would fall back to a small value and raise a false low alarm. Releasing the clear while the input is high catches a synchronizer that resets to zero: it would see a false rising edge and report a short pulse.

// File: rtl/pwm_mon_pkg.sv
package pwm_mon_pkg;
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_MEAS = 1'b1
  } meas_st_e;

  localparam int unsigned DEF_CNT_W = 12;
  localparam int unsigned DEF_PRE_W = 8;
endpackage

// File: rtl/pwm_mon_rst_sync.sv
module pwm_mon_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES clock edges
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_mon_edge.sv
module pwm_mon_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_async,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // reset to high so a pulse already high at release gives no rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pwm_async};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/pwm_mon_tick.sv
module pwm_mon_tick #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  // >= keeps the divider bounded if prescale shrinks mid-count
  assign tick = (div_q >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_mon_shadow.sv
module pwm_mon_shadow #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] hi_in,
  output logic [CNT_W-1:0] lo_act,
  output logic [CNT_W-1:0] hi_act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_act <= '0;
      hi_act <= '1;
    end else if (load) begin
      lo_act <= lo_in;
      hi_act <= hi_in;
    end
  end
endmodule

// File: rtl/pwm_mon_width.sv
module pwm_mon_width
  import pwm_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  input  logic [CNT_W-1:0] lo_act,
  input  logic [CNT_W-1:0] hi_act,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             alarm_lo,
  output logic             alarm_hi
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_st_e st_q;
  logic     over;
  logic     short_at_fall;
  logic     may_count;

  assign active        = (st_q == MS_MEAS);
  assign over          = active && (cnt > hi_act);
  assign short_at_fall = active && fall && (cnt < lo_act);
  assign may_count     = active && tick && !over && (cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MS_IDLE;
      cnt  <= '0;
    end else if (rise) begin
      st_q <= MS_MEAS;
      cnt  <= '0;
    end else if (fall) begin
      st_q <= MS_IDLE;
      cnt  <= '0;
    end else if (may_count) begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_lo <= 1'b0;
      alarm_hi <= 1'b0;
    end else begin
      alarm_lo <= alarm_lo | short_at_fall;
      alarm_hi <= alarm_hi | over;
    end
  end
endmodule

// File: rtl/pwm_duty_window_mon.sv
module pwm_duty_window_mon
  import pwm_mon_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned PRE_W = DEF_PRE_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] lim_lo,
  input  logic [CNT_W-1:0] lim_hi,
  output logic             alarm_lo,
  output logic             alarm_hi,
  output logic             alarm_any
);
  logic             rst_n_int;
  logic             rise;
  logic             fall;
  logic             tick;
  logic [CNT_W-1:0] lo_act;
  logic [CNT_W-1:0] hi_act;
  logic [CNT_W-1:0] width_cnt;
  logic             meas_active;

  pwm_mon_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .clr_n  (clr_n),
    .rst_n_o(rst_n_int)
  );

  pwm_mon_edge #(.SYNC_STAGES(2)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pwm_async(pwm_in),
    .rise     (rise),
    .fall     (fall)
  );

  pwm_mon_tick #(.PRE_W(PRE_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restart (rise),
    .prescale(prescale),
    .tick    (tick)
  );

  pwm_mon_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n_int),
    .load  (rise),
    .lo_in (lim_lo),
    .hi_in (lim_hi),
    .lo_act(lo_act),
    .hi_act(hi_act)
  );

  pwm_mon_width #(.CNT_W(CNT_W)) u_width (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rise    (rise),
    .fall    (fall),
    .tick    (tick),
    .lo_act  (lo_act),
    .hi_act  (hi_act),
    .cnt     (width_cnt),
    .active  (meas_active),
    .alarm_lo(alarm_lo),
    .alarm_hi(alarm_hi)
  );

  assign alarm_any = alarm_lo | alarm_hi;
endmodule

// File: rtl/pwm_duty_window_mon_chk.sv
module pwm_duty_window_mon_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             fall,
  input logic             active,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] hi_act,
  input logic             alarm_lo,
  input logic             alarm_hi,
  input logic             alarm_any
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1: a rising edge starts a fresh measurement at zero
  a_r1_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (active && cnt == '0));

  // R3: exceeding the high limit latches the alarm next cycle
  a_r3_hi_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt > hi_act) |=> alarm_hi);

  // R3: counting halts once over the high limit
  a_r3_count_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt > hi_act && !rise && !fall) |=> $stable(cnt));

  // R5: alarms are sticky
  a_r5_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_lo |=> alarm_lo);
  a_r5_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hi |=> alarm_hi);

  // R6: the count never wraps
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == CNT_MAX && !rise && !fall) |=> (cnt == CNT_MAX));

  // R7: the combined alarm follows its sources
  a_r7_any_on_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_lo) |-> alarm_any);
  a_r7_any_on_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_hi) |-> alarm_any);
endmodule

bind pwm_duty_window_mon pwm_duty_window_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .rise     (rise),
  .fall     (fall),
  .active   (meas_active),
  .cnt      (width_cnt),
  .hi_act   (hi_act),
  .alarm_lo (alarm_lo),
  .alarm_hi (alarm_hi),
  .alarm_any(alarm_any)
);

// File: tb/pwm_duty_window_mon_tb.sv
module pwm_duty_window_mon_tb;
  localparam int CNT_W = 12;
  localparam int PRE_W = 8;
  localparam int NV    = 11;

  typedef struct packed {
    logic [31:0] p;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] h;
    logic        elo;
    logic        ehi;
  } vec_t;

  // prescale, low limit, high limit, high cycles, expected lo/hi alarms
  localparam vec_t VECS [NV] = '{
    '{32'd0, 32'd10, 32'd20, 32'd16, 1'b0, 1'b0},
    '{32'd0, 32'd10, 32'd20, 32'd8,  1'b1, 1'b0},
    '{32'd0, 32'd10, 32'd20, 32'd30, 1'b0, 1'b1},
    '{32'd0, 32'd10, 32'd20, 32'd11, 1'b0, 1'b0},
    '{32'd0, 32'd10, 32'd20, 32'd10, 1'b1, 1'b0},
    '{32'd0, 32'd10, 32'd20, 32'd21, 1'b0, 1'b0},
    '{32'd0, 32'd10, 32'd20, 32'd22, 1'b0, 1'b1},
    '{32'd3, 32'd5,  32'd8,  32'd21, 1'b0, 1'b0},
    '{32'd3, 32'd5,  32'd8,  32'd20, 1'b1, 1'b0},
    '{32'd3, 32'd5,  32'd8,  32'd37, 1'b0, 1'b1},
    '{32'd3, 32'd5,  32'd8,  32'd36, 1'b0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             clr_n = 1'b0;
  logic [PRE_W-1:0] prescale = '0;
  logic             pwm_in = 1'b0;
  logic [CNT_W-1:0] lim_lo = '0;
  logic [CNT_W-1:0] lim_hi = '1;
  logic             alarm_lo;
  logic             alarm_hi;
  logic             alarm_any;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_duty_window_mon #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dut (
    .clk      (clk),
    .clr_n    (clr_n),
    .prescale (prescale),
    .pwm_in   (pwm_in),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .alarm_lo (alarm_lo),
    .alarm_hi (alarm_hi),
    .alarm_any(alarm_any)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    wait_n(2);
    clr_n = 1'b1;
    wait_n(4);
  endtask

  task automatic pulse(input int h);
    pwm_in = 1'b1;
    wait_n(h);
    pwm_in = 1'b0;
    wait_n(8);
  endtask

  initial begin
    wait_n(3);
    clr_n = 1'b1;
    wait_n(4);
    // R8: clean state after reset
    check("R8 reset alarm_lo", alarm_lo, 1'b0);
    check("R8 reset alarm_hi", alarm_hi, 1'b0);
    check("R7 reset alarm_any", alarm_any, 1'b0);

    // R1 R2 R3 R7: table of pulse widths around both limits
    for (int i = 0; i < NV; i++) begin
      do_clear();
      prescale = VECS[i].p[PRE_W-1:0];
      lim_lo   = VECS[i].lo[CNT_W-1:0];
      lim_hi   = VECS[i].hi[CNT_W-1:0];
      pulse(int'(VECS[i].h));
      check($sformatf("R2 vec%0d alarm_lo", i), alarm_lo, VECS[i].elo);
      check($sformatf("R3 vec%0d alarm_hi", i), alarm_hi, VECS[i].ehi);
      check($sformatf("R7 vec%0d alarm_any", i), alarm_any, VECS[i].elo | VECS[i].ehi);
    end

    // R5: a good pulse after a high alarm leaves it set
    do_clear();
    prescale = '0; lim_lo = 12'd10; lim_hi = 12'd20;
    pulse(30);
    pulse(16);
    check("R5 hi stays set", alarm_hi, 1'b1);
    check("R5 lo not set", alarm_lo, 1'b0);

    // R3: high alarm appears while input still high
    do_clear();
    pwm_in = 1'b1;
    wait_n(30);
    check("R3 hi during pulse", alarm_hi, 1'b1);
    check("R7 any during pulse", alarm_any, 1'b1);
    pwm_in = 1'b0;
    wait_n(8);

    // R4: limits changed mid-pulse do not affect it
    do_clear();
    lim_lo = 12'd10; lim_hi = 12'd20;
    pwm_in = 1'b1;
    wait_n(6);
    lim_hi = 12'd3;
    wait_n(10);
    pwm_in = 1'b0;
    wait_n(8);
    check("R4 no alarm on old limits", alarm_hi, 1'b0);
    pulse(16);
    check("R4 new limit applied", alarm_hi, 1'b1);

    // R6: saturation, no wrap into a false short pulse
    do_clear();
    lim_lo = 12'hFFF; lim_hi = 12'hFFF;
    pulse(5000);
    check("R6 no lo after saturation", alarm_lo, 1'b0);
    check("R6 no hi after saturation", alarm_hi, 1'b0);

    // R8: release during a high pulse, it must not be measured
    do_clear();
    lim_lo = 12'd10; lim_hi = 12'd20;
    pwm_in = 1'b1;
    wait_n(5);
    clr_n = 1'b0;
    wait_n(2);
    clr_n = 1'b1;
    wait_n(3);
    pwm_in = 1'b0;
    wait_n(8);
    check("R8 partial pulse ignored", alarm_lo, 1'b0);
    pulse(8);
    check("R8 next pulse measured", alarm_lo, 1'b1);

    // R8: asynchronous clear between edges
    #5;
    clr_n = 1'b0;
    #1;
    check("R8 async clear lo", alarm_lo, 1'b0);
    check("R8 async clear any", alarm_any, 1'b0);
    wait_n(2);
    clr_n = 1'b1;
    wait_n(4);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule